// File: doc/BRIEF.md
# Branch Target and Link Unit

This block resolves branch instructions in a small RISC pipeline. For each branch presented, it produces the next program counter. It also decides whether a link register is written, and whether the instruction that follows the branch (the delay slot) runs or is discarded.

The branch operand comes from one of two sources: a register value, or an already extended immediate. The decoded immediate modifier picks between them. Three further modifier bits are independent of one another:

- The link modifier turns a jump into a call.
- The absolute modifier makes the operand the target itself rather than an offset from the PC.
- The delay modifier lets the following instruction execute.

Condition evaluation happens upstream. The result arrives here as a single taken bit.

All results are registered, so they appear one cycle after the branch is presented. When a taken branch has its delay modifier clear, a squash pulse marks the next instruction as dead. If that next instruction is itself a branch, the unit drops it.

Top module: `bru_unit`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, out_valid, redirect, link_we and squash are 0 and next_pc, link_rd and link_val are 0.
- R2: A branch accepted at one clock edge (br_valid high and squash low) sets out_valid high right after that edge. Without an accepted branch, out_valid is low after the edge.
- R3: use_imm = 1 selects imm_op as the branch operand; use_imm = 0 selects reg_op.
- R4: A taken branch with mod_abs = 1 gives next_pc equal to the operand and redirect = 1.
- R5: A taken branch with mod_abs = 0 gives next_pc = pc_in + operand modulo 2^32 and redirect = 1.
- R6: A not-taken branch gives next_pc = pc_in + 4 and redirect = 0, and it never raises squash.
- R7: An accepted branch with mod_link = 1 and rd_idx not 0 raises link_we, with link_rd = rd_idx and link_val = pc_in of the branch, whether or not it is taken.
- R8: When rd_idx = 0, link_we stays low even with mod_link = 1, because register 0 ignores writes.
- R9: A taken branch with mod_delay = 0 raises squash for exactly one cycle, together with its outputs.
- R10: A taken branch with mod_delay = 1 leaves squash low.
- R11: A branch presented while squash is high is discarded. The following cycle shows out_valid = 0, link_we = 0 and squash = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A branch instruction is presented this cycle |
| pc_in | input | 32 | PC of the branch instruction |
| reg_op | input | 32 | Register operand |
| imm_op | input | 32 | Extended immediate operand |
| use_imm | input | 1 | Immediate modifier: 1 selects imm_op |
| taken | input | 1 | Branch condition result |
| mod_link | input | 1 | Link modifier: write the PC to rd_idx |
| mod_abs | input | 1 | Absolute modifier: the operand is the target |
| mod_delay | input | 1 | Delay modifier: the slot instruction executes |
| rd_idx | input | 5 | Destination register for the link |
| out_valid | output | 1 | Registered results are valid |
| redirect | output | 1 | The branch was taken; next_pc is a target |
| next_pc | output | 32 | Resolved next program counter |
| link_we | output | 1 | Link register write enable |
| link_rd | output | 5 | Link destination register |
| link_val | output | 32 | Value written to the link register |
| squash | output | 1 | Discard the delay-slot instruction |

## Verification
The only state this block holds is its output registers and the squash flag.

- A stuck or stale squash flag shows at the ports within one cycle. A valid branch in the next slot then either vanishes from out_valid when it should appear, or appears when it should have been dropped.
- A wrong operand select, target adder or fall-through step shows as a wrong next_pc on the very cycle after the branch.
- A link gate that ignores register 0 shows as link_we high for rd_idx = 0 on that same cycle.

// File: rtl/bru_pkg.sv
// Package: shared constants and decoded modifier bundle for the branch unit.
// Assumes the decode stage delivers modifiers already separated into bits.
package bru_pkg;

    // Byte distance between sequential instructions.
    localparam int BRU_PC_STEP = 4;

    // Decoded branch modifiers.
    typedef struct packed {
        logic use_imm;
        logic link;
        logic absolute;
        logic delay;
    } bru_mods_t;

endpackage

// File: rtl/bru_operand_sel.sv
// Module: picks the branch operand from the register or the immediate path.
// Assumes the immediate has already been extended to full width upstream.
module bru_operand_sel #(
    parameter int W = 32
) (
    input  logic         use_imm,
    input  logic [W-1:0] reg_op,
    input  logic [W-1:0] imm_op,
    output logic [W-1:0] operand
);

    // Purpose: immediate modifier chooses the operand source.
    always_comb begin
        operand = use_imm ? imm_op : reg_op;
    end

endmodule

// File: rtl/bru_target_calc.sv
// Module: forms the next PC from the branch PC, operand, absolute bit and taken bit.
// Assumes wrap-around arithmetic modulo 2^W.
module bru_target_calc #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] operand,
    input  logic         absolute,
    input  logic         taken,
    output logic [W-1:0] next_pc
);

    localparam logic [W-1:0] STEP_W = W'(STEP);

    logic [W-1:0] rel_target;
    logic [W-1:0] fall_pc;
    logic [W-1:0] target;

    // Purpose: compute relative and sequential candidates.
    always_comb begin
        rel_target = pc + operand;
        fall_pc    = pc + STEP_W;
    end

    // Purpose: choose target form, then taken versus fall-through.
    always_comb begin
        target  = absolute ? operand : rel_target;
        next_pc = taken ? target : fall_pc;
    end

endmodule

// File: rtl/bru_link_ctrl.sv
// Module: decides the link write and its data for an accepted branch.
// Assumes register index 0 is hardwired to zero and must never be written.
module bru_link_ctrl #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          accept,
    input  logic          link,
    input  logic [AW-1:0] rd,
    input  logic [W-1:0]  pc,
    output logic          we,
    output logic [AW-1:0] wr_rd,
    output logic [W-1:0]  wr_val
);

    logic rd_is_zero;

    // Purpose: gate writes to the zero register and pass the branch PC.
    always_comb begin
        rd_is_zero = (rd == '0);
        we         = accept && link && !rd_is_zero;
        wr_rd      = we ? rd : '0;
        wr_val     = we ? pc : '0;
    end

endmodule

// File: rtl/bru_slot_ctrl.sv
// Module: tracks the delay slot; raises squash after a taken branch without
// the delay modifier and refuses any branch that sits in a squashed slot.
// Assumes one instruction per cycle enters the unit.
module bru_slot_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic br_valid,
    input  logic taken,
    input  logic delay,
    output logic accept,
    output logic squash
);

    // Purpose: the slot instruction is dead while squash is high.
    always_comb begin
        accept = br_valid && !squash;
    end

    // Purpose: register the squash pulse for the following instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash <= 1'b0;
        end else begin
            squash <= accept && taken && !delay;
        end
    end

    // R9: squash lasts exactly one cycle.
    assert_squash_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !squash);

    // R11: a branch in the squashed slot is never accepted.
    assert_slot_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && br_valid) |-> !accept);

endmodule

// File: rtl/bru_unit.sv
// Module: top of the branch target and link unit. Combines operand
// selection, target calculation, link control and slot tracking, and
// registers all results for one-cycle latency.
// Assumes the condition is resolved upstream and delivered as 'taken'.
module bru_unit #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  reg_op,
    input  logic [W-1:0]  imm_op,
    input  logic          use_imm,
    input  logic          taken,
    input  logic          mod_link,
    input  logic          mod_abs,
    input  logic          mod_delay,
    input  logic [AW-1:0] rd_idx,
    output logic          out_valid,
    output logic          redirect,
    output logic [W-1:0]  next_pc,
    output logic          link_we,
    output logic [AW-1:0] link_rd,
    output logic [W-1:0]  link_val,
    output logic          squash
);

    import bru_pkg::*;

    localparam logic [W-1:0] STEP_W = W'(BRU_PC_STEP);

    bru_mods_t    mods;
    logic [W-1:0] operand;
    logic [W-1:0] npc_c;
    logic         accept;
    logic         lwe_c;
    logic [AW-1:0] lrd_c;
    logic [W-1:0] lval_c;

    // Purpose: bundle the decoded modifier bits.
    always_comb begin
        mods = '{use_imm: use_imm, link: mod_link, absolute: mod_abs, delay: mod_delay};
    end

    bru_operand_sel #(.W(W)) u_opsel (
        .use_imm (mods.use_imm),
        .reg_op  (reg_op),
        .imm_op  (imm_op),
        .operand (operand)
    );

    bru_target_calc #(.W(W), .STEP(BRU_PC_STEP)) u_tgt (
        .pc       (pc_in),
        .operand  (operand),
        .absolute (mods.absolute),
        .taken    (taken),
        .next_pc  (npc_c)
    );

    bru_slot_ctrl u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .taken    (taken),
        .delay    (mods.delay),
        .accept   (accept),
        .squash   (squash)
    );

    bru_link_ctrl #(.W(W), .AW(AW)) u_link (
        .accept (accept),
        .link   (mods.link),
        .rd     (rd_idx),
        .pc     (pc_in),
        .we     (lwe_c),
        .wr_rd  (lrd_c),
        .wr_val (lval_c)
    );

    // Purpose: register results of an accepted branch; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            redirect  <= 1'b0;
            next_pc   <= '0;
            link_we   <= 1'b0;
            link_rd   <= '0;
            link_val  <= '0;
        end else begin
            out_valid <= accept;
            redirect  <= accept && taken;
            next_pc   <= accept ? npc_c : '0;
            link_we   <= lwe_c;
            link_rd   <= lrd_c;
            link_val  <= lval_c;
        end
    end

    // R8: the zero register never receives a link write.
    assert_no_zero_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_rd != '0));

    // R6: a not-taken result is the sequential PC of the branch.
    assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !redirect) |-> (next_pc == $past(pc_in) + STEP_W));

    // R6: squash only follows a redirect.
    assert_squash_needs_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (redirect && out_valid));

    // R2: link writes only accompany valid results.
    assert_link_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> out_valid);

endmodule

// File: tb/bru_unit_bench.sv
module bru_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] pc_in = '0, reg_op = '0, imm_op = '0;
    logic        use_imm = 1'b0, taken = 1'b0;
    logic        mod_link = 1'b0, mod_abs = 1'b0, mod_delay = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic        out_valid, redirect, link_we, squash;
    logic [31:0] next_pc, link_val;
    logic [4:0]  link_rd;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic        v;
        logic        red;
        logic [31:0] npc;
        logic        lwe;
        logic [4:0]  lrd;
        logic [31:0] lval;
        logic        sq;
        string       tag;
    } exp_t;

    exp_t q[$];
    logic model_sq = 1'b0;

    always #2.5 clk = ~clk;

    bru_unit u_bru_unit (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .pc_in(pc_in),
        .reg_op(reg_op), .imm_op(imm_op), .use_imm(use_imm), .taken(taken),
        .mod_link(mod_link), .mod_abs(mod_abs), .mod_delay(mod_delay),
        .rd_idx(rd_idx), .out_valid(out_valid), .redirect(redirect),
        .next_pc(next_pc), .link_we(link_we), .link_rd(link_rd),
        .link_val(link_val), .squash(squash)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one instruction at the falling edge and pushes its expectation.
    task automatic drive(input logic v, input logic [31:0] pc, input logic [31:0] r,
                         input logic [31:0] im, input logic ui, input logic tk,
                         input logic lk, input logic ab, input logic dl,
                         input logic [4:0] rd, input string tag);
        exp_t e;
        logic acc;
        logic [31:0] op;
        @(negedge clk);
        br_valid = v; pc_in = pc; reg_op = r; imm_op = im; use_imm = ui;
        taken = tk; mod_link = lk; mod_abs = ab; mod_delay = dl; rd_idx = rd;
        acc  = v && !model_sq;
        op   = ui ? im : r;
        e.v  = acc;
        e.red = acc && tk;
        e.npc = !acc ? 32'h0 : (tk ? (ab ? op : pc + op) : pc + 32'd4);
        e.lwe = acc && lk && (rd != 5'd0);
        e.lrd = e.lwe ? rd : 5'd0;
        e.lval = e.lwe ? pc : 32'h0;
        e.sq = acc && tk && !dl;
        e.tag = tag;
        model_sq = e.sq;
        q.push_back(e);
    endtask

    // Monitor: samples two time units after each rising edge and compares.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " out_valid"}, 32'(out_valid), 32'(e.v));
                chk({e.tag, " redirect"},  32'(redirect),  32'(e.red));
                chk({e.tag, " squash"},    32'(squash),    32'(e.sq));
                chk({e.tag, " link_we"},   32'(link_we),   32'(e.lwe));
                if (e.v)   chk({e.tag, " next_pc"},  next_pc, e.npc);
                if (e.lwe) chk({e.tag, " link_rd"},  32'(link_rd), 32'(e.lrd));
                if (e.lwe) chk({e.tag, " link_val"}, link_val, e.lval);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset.
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 squash", 32'(squash), 0);
        chk("R1 link_we", 32'(link_we), 0);
        chk("R1 next_pc", next_pc, 0);
        chk("R1 link_val", link_val, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: idle cycle gives no valid output.
        drive(0, 32'h100, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
        // R5/R3: relative taken with register operand, delay set (R10).
        drive(1, 32'h1000, 32'h40, 32'h999, 0, 1, 0, 0, 1, 0, "R5 R3 R10 rel reg");
        // R3/R4: absolute taken with immediate operand, delay set.
        drive(1, 32'h2000, 32'h7, 32'h8000_0000, 1, 1, 0, 1, 1, 0, "R4 R3 abs imm");
        // R6: not taken, delay clear: fall-through, no squash.
        drive(1, 32'h3000, 32'h50, 0, 0, 0, 0, 0, 0, 0, "R6 not taken");
        // R5: negative offset wraps.
        drive(1, 32'h10, 32'hFFFF_FFF0, 0, 0, 1, 0, 0, 1, 0, "R5 backward");
        drive(1, 32'hFFFF_FFFC, 0, 32'h8, 1, 1, 0, 0, 1, 0, "R5 wrap");
        // R7: call with link, taken and not taken.
        drive(1, 32'h4000, 32'h20, 0, 0, 1, 1, 0, 1, 5'd15, "R7 call");
        drive(1, 32'h4100, 32'h20, 0, 0, 0, 1, 0, 1, 5'd31, "R7 link not taken");
        // R8: link to register 0 suppressed.
        drive(1, 32'h5000, 0, 32'h100, 1, 1, 1, 1, 1, 5'd0, "R8 zero reg");
        // R9: taken without delay squashes for one cycle.
        drive(1, 32'h6000, 32'h80, 0, 0, 1, 0, 0, 0, 0, "R9 squash");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 squash ends");
        // R11: a branch in the squashed slot is discarded, including its link.
        drive(1, 32'h7000, 32'h80, 0, 0, 1, 0, 1, 0, 0, "R9 squash again");
        drive(1, 32'h7004, 32'h44, 0, 0, 1, 1, 1, 0, 5'd9, "R11 dead slot");
        drive(1, 32'h7100, 32'h10, 0, 0, 1, 1, 0, 1, 5'd3, "R11 after dead slot");
        // R6: not-taken branch after a squash window still falls through.
        drive(1, 32'h8000, 32'h10, 0, 0, 0, 0, 1, 0, 0, "R6 not taken abs");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 tail idle");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 tail idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule